// File: doc/BRIEF.md
# ADC Scan Sequencer Control Register

This block holds the control and status register of a sixteen-input analog-to-digital converter and sequences its conversions. Software reads and writes one 8-bit register over simple read and write strobes. It selects a channel code, single or scan mode, and an interrupt enable, and sets a run bit to begin. The block then drives an abstract converter through a one-cycle start pulse that carries a 4-bit channel number, and waits for a one-cycle done pulse.

In single mode one channel is converted. The end flag then rises and the run bit drops by itself. In scan mode the channel code names a group of four inputs and how many of that group to convert. The group is swept in ascending order, again and again. The end flag rises at the end of every full sweep, until software clears the run bit or the force-stop input is asserted. The end flag drives an interrupt request when it is enabled. Software can clear the flag by writing 0 only after it has read the flag as 1. A data-transfer engine can also clear it by pulsing a strobe when it reads the result.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the register reads 0x00, and neither the interrupt nor the start pulse is asserted.
- R2: Software cannot set the end flag (bit 7). Writing 1 to it leaves it unchanged.
- R3: Writing 0 to bit 7 clears the end flag only if a read strobe saw the flag at 1 after it was last set. Without that read, the write leaves the flag at 1.
- R4: In single mode (bit 4 = 0), the done of the selected channel sets the end flag and returns the run bit (bit 5) to 0.
- R5: A pulse on the transfer-clear strobe clears the end flag.
- R6: The interrupt output is high exactly while the end flag and the interrupt enable (bit 6) are both 1.
- R7: In single mode, the start pulse carries the channel number equal to bits 3..0.
- R8: In scan mode, bits 3..2 select the group base (0, 4, 8 or 12). Bits 1..0 plus one give the number of channels, converted upward from the base.
- R9: In scan mode the end flag is set after each complete sweep. The run bit stays 1 and the sweep restarts at the base.
- R10: Writing 0 to the run bit during a scan abandons the outstanding conversion. Its done pulse neither sets the flag nor causes another start pulse.
- R11: A new run always begins with the group base channel, even after a scan was abandoned in the middle of a sweep.
- R12: Asserting the force-stop input clears the run bit and halts the start pulses.
- R13: Every start pulse lasts one cycle, and at most one conversion is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stop_i | input | 1 | Force stop of any running conversion |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (arms the flag clear) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Register contents |
| xfer_clr_i | input | 1 | Result read by transfer engine; clears end flag |
| conv_start_o | output | 1 | One-cycle conversion start |
| conv_chan_o | output | 4 | Channel number for the conversion |
| conv_done_i | input | 1 | One-cycle conversion complete |
| irq_o | output | 1 | End-of-conversion interrupt request |

## Verification
The assertions assume a converter that returns done only while a conversion is outstanding. They also assume software does not rewrite the mode or channel code while a run is active. The single-mode run-bit check further assumes that no write of the run bit coincides with a done. The bench keeps to these rules. Its converter model replies a fixed three cycles after each start. Mode and code change only after the run bit is 0. Aborts and stops are issued only after the pending start has been observed. A late done after an abort is still delivered, so the rule that it is ignored is exercised.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CSR_W  = 8;
  localparam int CHAN_W = 4;
  localparam int CNT_W  = 2;
  localparam int FLAG_B = 7;
  localparam int IE_B   = 6;
  localparam int RUN_B  = 5;
  localparam int SCAN_B = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ISSUE,
    SEQ_WAIT
  } seq_state_e;

  typedef struct packed {
    logic              flag;
    logic              ie;
    logic              run;
    logic              scan;
    logic [CHAN_W-1:0] chan;
  } csr_t;
endpackage

// File: rtl/adc_csr.sv
module adc_csr
  import adc_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [CSR_W-1:0] wdata_i,
  input  logic             xfer_clr_i,
  input  logic             stop_i,
  input  logic             fin_i,
  output csr_t             csr_o
);
  csr_t csr_q;
  logic armed_q;
  logic sw_clr;

  // write 0 clears only after the flag was read as 1
  assign sw_clr = wr_i && !wdata_i[FLAG_B] && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (wr_i) begin
        csr_q.ie   <= wdata_i[IE_B];
        csr_q.scan <= wdata_i[SCAN_B];
        csr_q.chan <= wdata_i[CHAN_W-1:0];
      end

      if (stop_i || (wr_i && !wdata_i[RUN_B]))
        csr_q.run <= 1'b0;
      else if (wr_i && wdata_i[RUN_B])
        csr_q.run <= 1'b1;
      else if (fin_i && !csr_q.scan)
        csr_q.run <= 1'b0;

      if (fin_i) begin
        csr_q.flag <= 1'b1;
        armed_q    <= 1'b0;
      end else if (xfer_clr_i || sw_clr) begin
        csr_q.flag <= 1'b0;
        armed_q    <= 1'b0;
      end else if (rd_i && csr_q.flag) begin
        armed_q    <= 1'b1;
      end
    end
  end

  assign csr_o = csr_q;
endmodule

// File: rtl/adc_chan_map.sv
module adc_chan_map #(
  parameter int CHAN_W = 4,
  parameter int CNT_W  = 2
) (
  input  logic [CHAN_W-1:0] code_i,
  input  logic              scan_i,
  output logic [CHAN_W-1:0] base_o,
  output logic [CNT_W-1:0]  last_o
);
  localparam int GRP_W = CHAN_W - CNT_W;

  logic [GRP_W-1:0] grp;
  assign grp = code_i[CHAN_W-1:CNT_W];

  always_comb begin
    if (scan_i) begin
      base_o = {grp, {CNT_W{1'b0}}};
      last_o = code_i[CNT_W-1:0];
    end else begin
      base_o = code_i;
      last_o = '0;
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CW = 4,
  parameter int NW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          kill_i,
  input  logic          scan_i,
  input  logic [CW-1:0] base_i,
  input  logic [NW-1:0] last_i,
  input  logic          done_i,
  output logic          start_o,
  output logic [CW-1:0] chan_o,
  output logic          fin_o
);
  seq_state_e state_q;
  logic [NW-1:0] idx_q;
  logic at_last;

  assign at_last = (idx_q == last_i);
  assign fin_o   = (state_q == SEQ_WAIT) && done_i && at_last && !kill_i;
  assign start_o = (state_q == SEQ_ISSUE);
  assign chan_o  = base_i + CW'(idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else if (kill_i) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else if (go_i) begin
      state_q <= SEQ_ISSUE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        SEQ_ISSUE: state_q <= SEQ_WAIT;
        SEQ_WAIT: if (done_i) begin
          if (at_last) begin
            idx_q   <= '0;
            state_q <= scan_i ? SEQ_ISSUE : SEQ_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= SEQ_ISSUE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [CSR_W-1:0]  bus_wdata_i,
  output logic [CSR_W-1:0]  bus_rdata_o,
  input  logic              xfer_clr_i,
  output logic              conv_start_o,
  output logic [CHAN_W-1:0] conv_chan_o,
  input  logic              conv_done_i,
  output logic              irq_o
);
  csr_t csr;
  logic fin, go, kill;
  logic [CHAN_W-1:0] base;
  logic [CNT_W-1:0]  last;

  assign kill = stop_i || (bus_wr_i && !bus_wdata_i[RUN_B]);
  assign go   = bus_wr_i && bus_wdata_i[RUN_B] && !csr.run && !stop_i;

  adc_csr u_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (bus_wr_i),
    .rd_i       (bus_rd_i),
    .wdata_i    (bus_wdata_i),
    .xfer_clr_i (xfer_clr_i),
    .stop_i     (stop_i),
    .fin_i      (fin),
    .csr_o      (csr)
  );

  adc_chan_map #(.CHAN_W(CHAN_W), .CNT_W(CNT_W)) u_map (
    .code_i (csr.chan),
    .scan_i (csr.scan),
    .base_o (base),
    .last_o (last)
  );

  adc_seq_fsm #(.CW(CHAN_W), .NW(CNT_W)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go),
    .kill_i  (kill),
    .scan_i  (csr.scan),
    .base_i  (base),
    .last_i  (last),
    .done_i  (conv_done_i),
    .start_o (conv_start_o),
    .chan_o  (conv_chan_o),
    .fin_o   (fin)
  );

  assign bus_rdata_o = csr;
  assign irq_o       = csr.flag & csr.ie;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stop_i,
  input logic       bus_wr_i,
  input logic [7:0] bus_rdata_o,
  input logic       conv_start_o,
  input logic [3:0] conv_chan_o,
  input logic       irq_o
);
  assert_irq_needs_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> bus_rdata_o[7] && bus_rdata_o[6]);

  assert_single_chan_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o && !bus_rdata_o[4] |-> conv_chan_o == bus_rdata_o[3:0]);

  assert_scan_chan_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o && bus_rdata_o[4] |->
      conv_chan_o[3:2] == bus_rdata_o[3:2] && conv_chan_o[1:0] <= bus_rdata_o[1:0]);

  assert_single_self_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_wr_i && $rose(bus_rdata_o[7]) && !bus_rdata_o[4] |-> !bus_rdata_o[5]);

  assert_stop_clears_run_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !bus_rdata_o[5]);

  assert_one_cycle_start_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  assert_start_needs_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> bus_rdata_o[5]);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stop_i       (stop_i),
  .bus_wr_i     (bus_wr_i),
  .bus_rdata_o  (bus_rdata_o),
  .conv_start_o (conv_start_o),
  .conv_chan_o  (conv_chan_o),
  .irq_o        (irq_o)
);

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop = 1'b0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       xclr = 1'b0;
  logic       cstart;
  logic [3:0] cchan;
  logic       cdone = 1'b0;
  logic       irq;

  int n_vec = 0;
  int n_bad = 0;
  logic [3:0] exp_q[$];
  bit finished = 0;

  always #10 clk = ~clk;

  adc_seq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .stop_i(stop),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .xfer_clr_i(xclr), .conv_start_o(cstart), .conv_chan_o(cchan),
    .conv_done_i(cdone), .irq_o(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // converter model: done three cycles after each start
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cdone = (cnt == 1);
      if (cnt > 0) cnt--;
      if (cstart) cnt = 3;
    end
  end

  // monitor: every start pulse must match the next expected channel (R7 R8 R13)
  initial begin
    logic prev = 1'b0;
    forever begin
      @(negedge clk);
      if (cstart) begin
        if (prev) check("R13", 8'(cstart), 8'h0);
        if (exp_q.size() == 0) check("R13", {4'h0, cchan}, 8'hFF);
        else check("R8", {4'h0, cchan}, {4'h0, exp_q.pop_front()});
      end
      prev = cstart;
    end
  end

  task automatic wr_reg(logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic xfer_pulse();
    @(negedge clk); xclr = 1'b1;
    @(negedge clk); xclr = 1'b0;
  endtask

  task automatic wait_flag(string req);
    for (int i = 0; i < 200 && !rdata[7]; i++) @(negedge clk);
    check(req, 8'(rdata[7]), 8'h1);
  endtask

  task automatic wait_drain(string req);
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    check(req, 8'(exp_q.size()), 8'h0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", rdata, 8'h00);
    check("R1", {6'h0, irq, cstart}, 8'h00);

    // R2: software cannot set the flag
    wr_reg(8'h80);
    check("R2", rdata, 8'h00);

    // R4 R7: single conversion on channel 9
    exp_q.push_back(4'd9);
    wr_reg(8'h29);
    wait_flag("R4");
    idle(1);
    check("R4", rdata, 8'h89);

    // R2 R6: writing 1 to flag keeps it; enable irq
    wr_reg(8'hC9);
    check("R2", rdata, 8'hC9);
    check("R6", 8'(irq), 8'h1);
    // R3: write 0 without prior read does nothing
    wr_reg(8'h49);
    check("R3", rdata, 8'hC9);
    rd_reg();
    wr_reg(8'h49);
    check("R3", rdata, 8'h49);
    check("R6", 8'(irq), 8'h0);

    // R5: transfer strobe clears flag
    exp_q.push_back(4'd5);
    wr_reg(8'h65);
    wait_flag("R5");
    idle(1);
    check("R6", 8'(irq), 8'h1);
    xfer_pulse();
    check("R5", rdata, 8'h45);

    // R7 edge channels
    exp_q.push_back(4'd15);
    wr_reg(8'h2F);
    wait_flag("R7");
    xfer_pulse();
    exp_q.push_back(4'd0);
    wr_reg(8'h20);
    wait_flag("R7");
    xfer_pulse();
    check("R7", rdata, 8'h00);

    // R8 R9: scan group 0, four channels, then a second sweep begins
    exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(2);
    exp_q.push_back(3); exp_q.push_back(0);
    wr_reg(8'h33);
    wait_flag("R9");
    wait_drain("R9");
    check("R9", rdata, 8'hB3);
    wr_reg(8'h13);
    idle(10);
    check("R10", rdata, 8'h93);
    xfer_pulse();

    // R8: group 1 single-channel scan repeats channel 4
    exp_q.push_back(4); exp_q.push_back(4);
    wr_reg(8'h34);
    wait_flag("R8");
    wait_drain("R8");
    wr_reg(8'h14);
    idle(10);
    check("R8", rdata, 8'h94);
    xfer_pulse();

    // R10: abort mid-sweep, late done ignored
    exp_q.push_back(12); exp_q.push_back(13);
    wr_reg(8'h3E);
    wait_drain("R10");
    wr_reg(8'h1E);
    idle(12);
    check("R10", rdata, 8'h1E);

    // R11 R12: restart at base, then force stop
    exp_q.push_back(12); exp_q.push_back(13); exp_q.push_back(14);
    exp_q.push_back(12);
    wr_reg(8'h3E);
    wait_flag("R11");
    wait_drain("R11");
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    idle(12);
    check("R12", rdata, 8'h9E);
    check("R12", 8'(exp_q.size()), 8'h0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule